// File: doc/BRIEF.md
# Writeback Slot Reservation Unit

This unit keeps the count of a shared pool of result-writeback slots in an out-of-order core. It decides which issue lanes may send an instruction in the current cycle, and which function units may write a result to the register file. The pool holds write-port count times writeback pipeline depth slots. By default the depth is one, so the pool has one slot per write port. A slot is taken when an instruction is granted and given back when a result has left the writeback pipeline (`wb_done_i`).

Loads are handled optimistically. A load takes its slot at issue as if it will hit in the first-level cache. On a miss the slot is returned at once, so a long miss does not block issue. When an early signal says the miss data is on its way, the load takes a slot again. That reservation comes before any new issue. If no slot is free, the reservation waits in a pending count and is served first in later cycles.

A build parameter selects a second policy. In that policy issue is never blocked, and the slot is taken only when a completing unit is granted a write port. A unit that finds no free slot simply stays ungranted until one frees.

Top module: `wb_slot_unit`

## Requirements
- R1: The pool holds WB_WIDTH*WB_DEPTH slots. After reset `occ_o` is 0 and `err_o` is 0, and `occ_o` never goes above the pool size.
- R2: In issue-claim mode each requesting issue lane is granted in ascending lane-index order while free slots remain. Each grant raises occupancy by one in the next cycle. Lanes beyond the free count are denied.
- R3: Every bit of `wb_done_i` frees one slot. Slots freed in a cycle count as free for the grants and reservations of that same cycle.
- R4: In issue-claim mode every set bit of `ld_miss_i` frees one slot in that cycle.
- R5: In issue-claim mode every set bit of `ld_ret_i` reserves one slot before any issue lane is considered. Reservations that find no free slot are held (up to MISS_MAX) and served ahead of issue in later cycles.
- R6: At most WB_WIDTH bits of `wb_gnt_o` are set per cycle. The lowest-indexed requesting units win, and a unit that keeps requesting is granted in a later cycle. More issue lanes than write ports may be granted in one cycle.
- R7: In completion-claim mode every issue request is granted. Write grants are limited to the smaller of WB_WIDTH and the free slots, and each one takes a slot. `ld_miss_i` and `ld_ret_i` have no effect.
- R8: A cycle whose releases exceed the current occupancy sets `err_o`, which stays set until reset. Occupancy never drops below 0.
- R9: `flush_i` makes occupancy 0 in the next cycle and discards all pending reservations. `err_o` is not cleared by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Pipeline flush: clears occupancy and pending reservations |
| issue_req_i | input | ISSUE_W | Issue request per lane |
| issue_gnt_o | output | ISSUE_W | Issue grant per lane (same cycle) |
| fu_req_i | input | N_FU | Function unit has a result to write |
| wb_gnt_o | output | N_FU | Register-file write grant per unit (same cycle) |
| wb_done_i | input | WB_WIDTH | Each bit: one result left the writeback pipeline |
| ld_miss_i | input | LD_PORTS | Each bit: a load missed and returns its slot |
| ld_ret_i | input | LD_PORTS | Each bit: early notice that miss data is returning |
| occ_o | output | clog2(POOL+1) | Slots currently held |
| err_o | output | 1 | Sticky flag: release without a held slot |

## Verification
Releases and new claims often happen in the same cycle. The bench pairs `wb_done_i` or `ld_miss_i` pulses with issue requests on a full pool, and with early-return pulses that compete with issue lanes. The expected grants must then show the freed slot going to the return first and to the lowest lane next. A bench-side arithmetic ledger, fed the same stimulus, is compared with the grants in the same cycle and with `occ_o` one cycle later. This is done in both claim modes, through directed sequences and a long pseudo-random sweep.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
   typedef enum logic {
      CLAIM_ON_ISSUE    = 1'b0,
      CLAIM_ON_COMPLETE = 1'b1
   } wbs_claim_e;
endpackage

// File: rtl/wbs_count.sv
module wbs_count #(
   parameter int N  = 4,
   parameter int CW = 4
) (
   input  logic [N-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);
   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
   end
endmodule

// File: rtl/wbs_pick.sv
module wbs_pick #(
   parameter int N  = 4,
   parameter int CW = 4
) (
   input  logic [N-1:0]  req_i,
   input  logic [CW-1:0] lim_i,
   output logic [N-1:0]  gnt_o
);
   logic [CW-1:0] taken;
   always_comb begin
      taken = '0;
      for (int i = 0; i < N; i++) begin
         gnt_o[i] = req_i[i] && (taken < lim_i);
         if (gnt_o[i]) taken = taken + CW'(1);
      end
   end
endmodule

// File: rtl/wbs_ledger.sv
module wbs_ledger #(
   parameter int POOL     = 2,
   parameter int MISS_MAX = 7,
   parameter int CW       = 6,
   parameter int OW       = 2,
   parameter int PW       = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic [CW-1:0] rel_cnt_i,
   input  logic [CW-1:0] ret_cnt_i,
   input  logic [CW-1:0] claim_cnt_i,
   output logic [CW-1:0] avail_o,
   output logic [OW-1:0] occ_o,
   output logic          err_o
);
   logic [OW-1:0] occ_q;
   logic [PW-1:0] pend_q;
   logic          err_q;
   logic [CW-1:0] occ_w, rel_eff, avail0, want, take, pend_n, occ_n;
   logic          over_rel;

   always_comb begin
      occ_w    = CW'(occ_q);
      over_rel = rel_cnt_i > occ_w;
      rel_eff  = over_rel ? occ_w : rel_cnt_i;
      avail0   = CW'(POOL) - occ_w + rel_eff;
      want     = CW'(pend_q) + ret_cnt_i;
      take     = (want < avail0) ? want : avail0;
      avail_o  = avail0 - take;
      pend_n   = want - take;
      if (pend_n > CW'(MISS_MAX)) pend_n = CW'(MISS_MAX);
      occ_n    = occ_w - rel_eff + take + claim_cnt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q  <= '0;
         pend_q <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= err_q | over_rel;
         if (flush_i) begin
            occ_q  <= '0;
            pend_q <= '0;
         end else begin
            occ_q  <= OW'(occ_n);
            pend_q <= PW'(pend_n);
         end
      end
   end

   assign occ_o = occ_q;
   assign err_o = err_q;

   assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OW'(POOL));
   assert_claim_within_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      claim_cnt_i <= avail_o);
   assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (occ_q == '0) && (pend_q == '0));
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/wb_slot_unit.sv
module wb_slot_unit
   import wbs_pkg::*;
#(
   parameter int         ISSUE_W    = 2,
   parameter int         WB_WIDTH   = 2,
   parameter int         WB_DEPTH   = 1,
   parameter int         N_FU       = 4,
   parameter int         LD_PORTS   = 2,
   parameter int         MISS_MAX   = 7,
   parameter wbs_claim_e CLAIM_MODE = CLAIM_ON_ISSUE,
   localparam int        POOL       = WB_WIDTH * WB_DEPTH,
   localparam int        OW         = $clog2(POOL + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush_i,
   input  logic [ISSUE_W-1:0]  issue_req_i,
   output logic [ISSUE_W-1:0]  issue_gnt_o,
   input  logic [N_FU-1:0]     fu_req_i,
   output logic [N_FU-1:0]     wb_gnt_o,
   input  logic [WB_WIDTH-1:0] wb_done_i,
   input  logic [LD_PORTS-1:0] ld_miss_i,
   input  logic [LD_PORTS-1:0] ld_ret_i,
   output logic [OW-1:0]       occ_o,
   output logic                err_o
);
   localparam int  CW  = $clog2(POOL + WB_WIDTH + 2*LD_PORTS + MISS_MAX + N_FU + ISSUE_W + 1) + 1;
   localparam int  PW  = $clog2(MISS_MAX + 1);
   localparam bit  AT_ISSUE = (CLAIM_MODE == CLAIM_ON_ISSUE);

   initial begin
      assert (WB_WIDTH >= 1) else $fatal(1, "WB_WIDTH must be at least 1");
      assert (WB_DEPTH >= 1) else $fatal(1, "WB_DEPTH must be at least 1");
      assert (ISSUE_W >= 1 && N_FU >= 1 && LD_PORTS >= 1) else $fatal(1, "port counts must be positive");
      assert (MISS_MAX >= 1) else $fatal(1, "MISS_MAX must be at least 1");
   end

   logic [CW-1:0] done_cnt, miss_cnt, ret_cnt, iss_cnt, wbg_cnt;
   logic [CW-1:0] rel_cnt, ret_use, claim_cnt, avail, wb_lim;

   wbs_count #(.N(WB_WIDTH), .CW(CW)) u_cnt_done (.vec_i(wb_done_i),   .cnt_o(done_cnt));
   wbs_count #(.N(LD_PORTS), .CW(CW)) u_cnt_miss (.vec_i(ld_miss_i),   .cnt_o(miss_cnt));
   wbs_count #(.N(LD_PORTS), .CW(CW)) u_cnt_ret  (.vec_i(ld_ret_i),    .cnt_o(ret_cnt));
   wbs_count #(.N(ISSUE_W),  .CW(CW)) u_cnt_iss  (.vec_i(issue_gnt_o), .cnt_o(iss_cnt));
   wbs_count #(.N(N_FU),     .CW(CW)) u_cnt_wbg  (.vec_i(wb_gnt_o),    .cnt_o(wbg_cnt));

   // Load events only move slots when slots are taken at issue (R4, R5, R7).
   assign rel_cnt   = done_cnt + (AT_ISSUE ? miss_cnt : '0);
   assign ret_use   = AT_ISSUE ? ret_cnt : '0;
   assign claim_cnt = AT_ISSUE ? iss_cnt : wbg_cnt;
   assign wb_lim    = (AT_ISSUE || (avail >= CW'(WB_WIDTH))) ? CW'(WB_WIDTH) : avail;

   wbs_ledger #(.POOL(POOL), .MISS_MAX(MISS_MAX), .CW(CW), .OW(OW), .PW(PW)) u_ledger (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .rel_cnt_i(rel_cnt), .ret_cnt_i(ret_use), .claim_cnt_i(claim_cnt),
      .avail_o(avail), .occ_o(occ_o), .err_o(err_o));

   generate
      if (AT_ISSUE) begin : g_issue_claim
         wbs_pick #(.N(ISSUE_W), .CW(CW)) u_iss_pick (
            .req_i(issue_req_i), .lim_i(avail), .gnt_o(issue_gnt_o));
      end else begin : g_done_claim
         assign issue_gnt_o = issue_req_i;
      end
   endgenerate

   wbs_pick #(.N(N_FU), .CW(CW)) u_wb_pick (
      .req_i(fu_req_i), .lim_i(wb_lim), .gnt_o(wb_gnt_o));

   assert_wb_ports_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wb_gnt_o) <= WB_WIDTH);
   assert_wb_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_gnt_o & ~fu_req_i) == '0);
   assert_iss_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_gnt_o & ~issue_req_i) == '0);

   generate
      for (genvar i = 1; i < N_FU; i++) begin : g_prio_chk
         localparam logic [N_FU-1:0] LOW = {N_FU{1'b1}} >> (N_FU - i);
         assert_wb_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wb_gnt_o[i] |-> (((fu_req_i & ~wb_gnt_o) & LOW) == '0));
      end
   endgenerate
endmodule

// File: tb/wb_slot_unit_test.sv
module wb_slot_unit_test;
   import wbs_pkg::*;

   localparam int POOL = 4;
   localparam int WBW  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic [2:0] iss = '0;
   logic [3:0] fu = '0;
   logic [1:0] done = '0, miss = '0, ret = '0;
   logic [2:0] iss_g [2];
   logic [3:0] wb_g [2];
   logic [2:0] occ [2];
   logic       err [2];

   int checks = 0, fails = 0;
   int m_occ [2], m_pend [2], m_err [2];
   int x_occ [2], x_pend [2], x_err [2];

   always #2 clk = ~clk;

   wb_slot_unit #(.ISSUE_W(3), .WB_WIDTH(2), .WB_DEPTH(2), .N_FU(4), .LD_PORTS(2),
                  .MISS_MAX(7), .CLAIM_MODE(CLAIM_ON_ISSUE)) uut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush), .issue_req_i(iss), .issue_gnt_o(iss_g[0]),
      .fu_req_i(fu), .wb_gnt_o(wb_g[0]), .wb_done_i(done), .ld_miss_i(miss), .ld_ret_i(ret),
      .occ_o(occ[0]), .err_o(err[0]));

   wb_slot_unit #(.ISSUE_W(3), .WB_WIDTH(2), .WB_DEPTH(2), .N_FU(4), .LD_PORTS(2),
                  .MISS_MAX(7), .CLAIM_MODE(CLAIM_ON_COMPLETE)) uut_cm (
      .clk(clk), .rst_n(rst_n), .flush_i(flush), .issue_req_i(iss), .issue_gnt_o(iss_g[1]),
      .fu_req_i(fu), .wb_gnt_o(wb_g[1]), .wb_done_i(done), .ld_miss_i(miss), .ld_ret_i(ret),
      .occ_o(occ[1]), .err_o(err[1]));

   function automatic int ones(logic [3:0] v);
      return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
   endfunction

   task automatic chk(string tag, string what, int k, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s inst%0d actual=%0d expected=%0d", tag, what, k, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; iss = '0; fu = '0; done = '0; miss = '0; ret = '0; flush = 1'b0;
      for (int k = 0; k < 2; k++) begin m_occ[k] = 0; m_pend[k] = 0; m_err[k] = 0; end
      repeat (2) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      for (int k = 0; k < 2; k++) begin
         chk("R1", "reset occ", k, int'(occ[k]), 0);
         chk("R1", "reset err", k, int'(err[k]), 0);
      end
   endtask

   // One cycle: drive, compare same-cycle grants, then next-cycle occupancy.
   task automatic step(string tag, logic [2:0] i_v, logic [3:0] f_v, logic [1:0] d_v,
                       logic [1:0] m_v, logic [1:0] r_v, logic fl);
      @(negedge clk);
      iss = i_v; fu = f_v; done = d_v; miss = m_v; ret = r_v; flush = fl;
      #1;
      for (int k = 0; k < 2; k++) begin
         bit im = (k == 0);
         int rel, re, a0, want, take, a1, lim, n, claims;
         logic [2:0] eg = '0;
         logic [3:0] ew = '0;
         rel = ones({2'b0, d_v}) + (im ? ones({2'b0, m_v}) : 0);
         x_err[k] = m_err[k] | ((rel > m_occ[k]) ? 1 : 0);
         re = (rel > m_occ[k]) ? m_occ[k] : rel;
         a0 = POOL - m_occ[k] + re;
         want = m_pend[k] + (im ? ones({2'b0, r_v}) : 0);
         take = (want < a0) ? want : a0;
         a1 = a0 - take;
         n = 0;
         for (int i = 0; i < 3; i++)
            if (i_v[i] && (!im || n < a1)) begin eg[i] = 1'b1; n++; end
         lim = im ? WBW : ((a1 < WBW) ? a1 : WBW);
         n = 0;
         for (int i = 0; i < 4; i++)
            if (f_v[i] && n < lim) begin ew[i] = 1'b1; n++; end
         claims = im ? ones({1'b0, eg}) : ones(ew);
         x_pend[k] = (want - take > 7) ? 7 : want - take;
         x_occ[k]  = m_occ[k] - re + take + claims;
         if (fl) begin x_occ[k] = 0; x_pend[k] = 0; end
         chk(tag, "issue_gnt", k, int'(iss_g[k]), int'(eg));
         chk(tag, "wb_gnt", k, int'(wb_g[k]), int'(ew));
      end
      @(posedge clk);
      #1;
      for (int k = 0; k < 2; k++) begin
         m_occ[k] = x_occ[k]; m_pend[k] = x_pend[k]; m_err[k] = x_err[k];
         chk(tag, "occ", k, int'(occ[k]), m_occ[k]);
         chk(tag, "err", k, int'(err[k]), m_err[k]);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      do_reset();
      // R2 / R6: three lanes granted at once with only two write ports; occ 3
      step("R2", 3'b111, 4'b0000, 2'b00, 2'b00, 2'b00, 1'b0);
      // R2: one free slot, only lane 0 granted; occ 4
      step("R2", 3'b111, 4'b0000, 2'b00, 2'b00, 2'b00, 1'b0);
      // R3: full pool, a release in the same cycle lets lane 0 issue
      step("R3", 3'b001, 4'b0000, 2'b01, 2'b00, 2'b00, 1'b0);
      // R4: two misses free two slots; occ 2 (ignored in completion mode, R7)
      step("R4", 3'b000, 4'b0000, 2'b00, 2'b11, 2'b00, 1'b0);
      // R5: returns take both free slots ahead of issue lanes
      step("R5", 3'b111, 4'b0000, 2'b00, 2'b00, 2'b11, 1'b0);
      // R5: return on a full pool waits pending
      step("R5", 3'b000, 4'b0000, 2'b00, 2'b00, 2'b01, 1'b0);
      // R5: freed slot goes to the pending return, not to lane 0
      step("R5", 3'b001, 4'b0000, 2'b01, 2'b00, 2'b00, 1'b0);
      // R6: four requesters, two lowest granted; losers retried next cycle
      step("R6", 3'b000, 4'b1111, 2'b00, 2'b00, 2'b00, 1'b0);
      step("R6", 3'b000, 4'b1100, 2'b00, 2'b00, 2'b00, 1'b0);
      // R7: completion mode grants limited by free slots, issue always granted
      step("R7", 3'b101, 4'b1111, 2'b00, 2'b00, 2'b00, 1'b0);
      step("R7", 3'b000, 4'b1111, 2'b00, 2'b00, 2'b00, 1'b0);
      step("R7", 3'b000, 4'b1111, 2'b00, 2'b10, 2'b01, 1'b0);
      // R8: drain then over-release sets the sticky flag, occ floors at 0
      step("R8", 3'b000, 4'b0000, 2'b11, 2'b00, 2'b00, 1'b0);
      step("R8", 3'b000, 4'b0000, 2'b11, 2'b00, 2'b00, 1'b0);
      step("R8", 3'b000, 4'b0000, 2'b01, 2'b00, 2'b00, 1'b0);
      step("R8", 3'b000, 4'b0000, 2'b00, 2'b00, 2'b00, 1'b0);
      // R9: fill, queue two pending returns, flush, then a single issue gives occ 1
      do_reset();
      step("R9", 3'b111, 4'b0011, 2'b00, 2'b00, 2'b00, 1'b0);
      step("R9", 3'b001, 4'b0011, 2'b00, 2'b00, 2'b00, 1'b0);
      step("R9", 3'b000, 4'b0000, 2'b00, 2'b00, 2'b11, 1'b0);
      step("R9", 3'b000, 4'b0000, 2'b00, 2'b00, 2'b00, 1'b1);
      step("R9", 3'b001, 4'b0000, 2'b00, 2'b00, 2'b00, 1'b0);
      // R3 / R5 / R6 sweep with mixed releases, returns, misses and flushes
      do_reset();
      for (int c = 0; c < 4000; c++) begin
         logic [2:0] i_v = 3'($urandom);
         logic [3:0] f_v = 4'($urandom);
         logic [1:0] d_v = 2'($urandom) & {2{($urandom % 3) != 0}};
         logic [1:0] m_v = 2'($urandom) & {2{($urandom % 4) == 0}};
         logic [1:0] r_v = 2'($urandom) & {2{($urandom % 4) == 0}};
         logic       fl  = (($urandom % 97) == 0);
         if (m_pend[0] > 3) r_v = '0;
         if (c == 2000) begin do_reset(); end
         step("R3", i_v, f_v, d_v, m_v, r_v, fl);
      end
      finish_run();
   end
endmodule